// File: doc/BRIEF.md
# Bitplane DMA Slot Sequencer

This block decides, for each memory-access slot of a raster line, whether that slot is used for a bitplane fetch and which plane the fetch serves. It keeps two programmable horizontal fetch-window registers, start and stop. It tracks a horizontal window flag, a stop-seen flag and a vertical window flag. Each granted slot produces a one-cycle request that carries a plane index. When a line that contained at least one fetch ends, the block pulses an end-of-line strobe so that the plane pointers can add their modulos.

A raster timing generator presents the slots one at a time with `slot_valid`. It marks the last cycle of each line with `line_end`, and on that cycle it gives the number of the line that begins next. The plane data path reports each completed delivery of plane data on `data_ack`. A register bus writes the window registers as whole 16-bit words. Inside the fetch window the planes are served in a fixed interleaved order: groups of eight slots in low resolution and groups of four slots in high resolution.

There is no data stream at this block's edge. `fetch_req` is a strobe without a ready, because the block owns the slot it grants. A slot that is not granted is left free for other bus users.

Top module: `bpl_slot_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `fetch_req`, `fetch_plane`, `did_fetch` and `eol_modulo` are all 0, and every window flag is clear.
- R2: A write to offset 0x092 loads the whole 16-bit start register, and a write to 0x094 loads the whole 16-bit stop register, with no masking and no shifting. Writes to any other offset change neither register.
- R3: The horizontal window opens on the slot whose zero-extended index equals the start register. That slot may already be granted.
- R4: The slot that matches the stop register marks the window as ending. The window then closes at the first `data_ack` seen while it is marked, that slot included. Without that acknowledge, fetching continues past the stop slot.
- R5: On a `line_end` cycle, the vertical flag is set if `new_line` equals `vwin_start` and cleared if it equals `vwin_stop`; the clear wins when both match. No slot is granted while the vertical flag is clear.
- R6: No slot is granted while `dma_bpl_en` is 0.
- R7: In low resolution (`hires`=0), slot index mod 8 maps to a plane as follows: 1→3, 2→5, 3→1, 5→2, 6→4, 7→0. Slots with index mod 8 equal to 0 or 4 never fetch.
- R8: In high resolution (`hires`=1), slot index mod 4 maps to a plane as follows: 0→3, 1→1, 2→2, 3→0.
- R9: A mapped plane is granted only if its index is less than `plane_cnt`.
- R10: A granted slot raises `fetch_req` for exactly one cycle, on the cycle after the slot, with the plane index on `fetch_plane`. Cycles with `slot_valid`=0 grant nothing and do not open the window.
- R11: `did_fetch` rises together with the first `fetch_req` of a line and stays high until `line_end`. On the cycle after `line_end`, `eol_modulo` pulses only if the line had a fetch, and `did_fetch` and the horizontal and stop-seen flags are clear, so the next line needs a new start match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| slot_valid | input | 1 | A slot is presented this cycle |
| slot_idx | input | 9 | Index of the presented slot within the line |
| data_ack | input | 1 | Plane data delivery completed |
| line_end | input | 1 | Last cycle of the line |
| new_line | input | 9 | Number of the next line, sampled with line_end |
| vwin_start | input | 9 | Vertical window first line |
| vwin_stop | input | 9 | Vertical window stop line |
| dma_bpl_en | input | 1 | Bitplane DMA enable |
| hires | input | 1 | High resolution slot order |
| plane_cnt | input | 3 | Number of active planes (0 to 6) |
| fetch_req | output | 1 | One-cycle fetch request |
| fetch_plane | output | 3 | Plane served by the request |
| did_fetch | output | 1 | A fetch occurred on the current line |
| eol_modulo | output | 1 | End-of-line modulo pulse |

## Verification
Every result is registered once, so `fetch_req`, `fetch_plane` and `did_fetch` are due one edge after the slot that caused them. `eol_modulo` is due one edge after `line_end`. A register write takes effect on the first slot after the write cycle. The bench drives each input on a falling edge and samples the outputs on the next falling edge, so each check sees exactly the edge on which its result becomes visible. A reference model in the bench updates its window flags slot by slot in the order the requirements give.

// File: rtl/bpl_seq_pkg.sv
package bpl_seq_pkg;

  typedef struct packed {
    logic       hit;
    logic [2:0] plane;
  } plane_sel_t;

  // Fixed interleave of planes over a slot group.
  function automatic plane_sel_t map_slot(input logic hi, input logic [2:0] s);
    plane_sel_t r;
    r.hit   = 1'b1;
    r.plane = 3'd0;
    if (hi) begin
      case (s[1:0])
        2'd0: r.plane = 3'd3;
        2'd1: r.plane = 3'd1;
        2'd2: r.plane = 3'd2;
        default: r.plane = 3'd0;
      endcase
    end else begin
      case (s)
        3'd1: r.plane = 3'd3;
        3'd2: r.plane = 3'd5;
        3'd3: r.plane = 3'd1;
        3'd5: r.plane = 3'd2;
        3'd6: r.plane = 3'd4;
        3'd7: r.plane = 3'd0;
        default: r.hit = 1'b0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/bpl_win_regs.sv
module bpl_win_regs #(
  parameter int ADDR_W    = 9,
  parameter int REG_W     = 16,
  parameter logic [ADDR_W-1:0] START_OFS = 9'h092,
  parameter logic [ADDR_W-1:0] STOP_OFS  = 9'h094
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  win_start,
  output logic [REG_W-1:0]  win_stop
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_start <= '0;
      win_stop  <= '0;
    end else if (wr) begin
      if (addr == START_OFS) win_start <= wdata;
      if (addr == STOP_OFS)  win_stop  <= wdata;
    end
  end
endmodule

// File: rtl/bpl_win_flags.sv
module bpl_win_flags #(
  parameter int SLOT_W = 9,
  parameter int LINE_W = 9,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_valid,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [REG_W-1:0]  win_start,
  input  logic [REG_W-1:0]  win_stop,
  input  logic              data_ack,
  input  logic              line_end,
  input  logic [LINE_W-1:0] new_line,
  input  logic [LINE_W-1:0] vwin_start,
  input  logic [LINE_W-1:0] vwin_stop,
  output logic              h_open,
  output logic              v_open
);
  localparam int PAD_W = REG_W - SLOT_W;

  logic [REG_W-1:0] slot_wide;
  logic start_hit, stop_hit, h_q, last_q, ending;

  assign slot_wide = {{PAD_W{1'b0}}, slot_idx};
  assign start_hit = slot_valid && (slot_wide == win_start);
  assign stop_hit  = slot_valid && (slot_wide == win_stop);
  assign h_open    = h_q || start_hit;
  assign ending    = last_q || stop_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_q    <= 1'b0;
      last_q <= 1'b0;
      v_open <= 1'b0;
    end else if (line_end) begin
      h_q    <= 1'b0;
      last_q <= 1'b0;
      if (new_line == vwin_stop)       v_open <= 1'b0;
      else if (new_line == vwin_start) v_open <= 1'b1;
    end else begin
      last_q <= ending;
      h_q    <= h_open && !(data_ack && ending);
    end
  end
endmodule

// File: rtl/bpl_plane_map.sv
module bpl_plane_map
  import bpl_seq_pkg::*;
#(
  parameter int SLOT_W  = 9,
  parameter int PLANE_W = 3
) (
  input  logic [SLOT_W-1:0]  slot_idx,
  input  logic               hires,
  input  logic [PLANE_W-1:0] plane_cnt,
  output logic               usable,
  output logic [PLANE_W-1:0] plane
);
  plane_sel_t sel;
  always_comb begin
    sel    = map_slot(hires, slot_idx[2:0]);
    plane  = sel.plane;
    usable = sel.hit && (sel.plane < plane_cnt);
  end
endmodule

// File: rtl/bpl_slot_seq.sv
module bpl_slot_seq #(
  parameter int ADDR_W  = 9,
  parameter int REG_W   = 16,
  parameter int SLOT_W  = 9,
  parameter int LINE_W  = 9,
  parameter int PLANE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               slot_valid,
  input  logic [SLOT_W-1:0]  slot_idx,
  input  logic               data_ack,
  input  logic               line_end,
  input  logic [LINE_W-1:0]  new_line,
  input  logic [LINE_W-1:0]  vwin_start,
  input  logic [LINE_W-1:0]  vwin_stop,
  input  logic               dma_bpl_en,
  input  logic               hires,
  input  logic [PLANE_W-1:0] plane_cnt,
  output logic               fetch_req,
  output logic [PLANE_W-1:0] fetch_plane,
  output logic               did_fetch,
  output logic               eol_modulo
);
  logic [REG_W-1:0]   win_start, win_stop;
  logic               h_open, v_open, usable, grant;
  logic [PLANE_W-1:0] plane;

  bpl_win_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .win_start(win_start), .win_stop(win_stop)
  );

  bpl_win_flags #(.SLOT_W(SLOT_W), .LINE_W(LINE_W), .REG_W(REG_W)) flags_i (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_idx(slot_idx),
    .win_start(win_start), .win_stop(win_stop), .data_ack(data_ack),
    .line_end(line_end), .new_line(new_line), .vwin_start(vwin_start),
    .vwin_stop(vwin_stop), .h_open(h_open), .v_open(v_open)
  );

  bpl_plane_map #(.SLOT_W(SLOT_W), .PLANE_W(PLANE_W)) map_i (
    .slot_idx(slot_idx), .hires(hires), .plane_cnt(plane_cnt),
    .usable(usable), .plane(plane)
  );

  assign grant = slot_valid && dma_bpl_en && h_open && v_open && usable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_req   <= 1'b0;
      fetch_plane <= '0;
      did_fetch   <= 1'b0;
      eol_modulo  <= 1'b0;
    end else begin
      fetch_req   <= grant;
      fetch_plane <= grant ? plane : '0;
      eol_modulo  <= line_end && (did_fetch || grant);
      did_fetch   <= !line_end && (did_fetch || grant);
    end
  end
endmodule

// File: rtl/bpl_slot_seq_chk.sv
module bpl_slot_seq_chk #(
  parameter int SLOT_W  = 9,
  parameter int PLANE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               slot_valid,
  input logic [SLOT_W-1:0]  slot_idx,
  input logic               line_end,
  input logic               dma_bpl_en,
  input logic               hires,
  input logic [PLANE_W-1:0] plane_cnt,
  input logic               fetch_req,
  input logic [PLANE_W-1:0] fetch_plane,
  input logic               did_fetch,
  input logic               eol_modulo
);
  // R10
  req_from_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> $past(slot_valid));
  // R6
  req_needs_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> $past(dma_bpl_en));
  // R9
  plane_in_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (fetch_plane < $past(plane_cnt)));
  // R7
  lores_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !$past(hires)) |-> ($past(slot_idx[1:0]) != 2'b00));
  // R11
  eol_after_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eol_modulo |-> $past(line_end));
  // R11
  did_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_end) |-> !did_fetch);
endmodule

bind bpl_slot_seq bpl_slot_seq_chk #(.SLOT_W(SLOT_W), .PLANE_W(PLANE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_idx(slot_idx),
  .line_end(line_end), .dma_bpl_en(dma_bpl_en), .hires(hires),
  .plane_cnt(plane_cnt), .fetch_req(fetch_req), .fetch_plane(fetch_plane),
  .did_fetch(did_fetch), .eol_modulo(eol_modulo)
);

// File: tb/bpl_slot_seq_tb.sv
module bpl_slot_seq_tb_top;
  localparam time HALF = 2.5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [8:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        slot_valid = 1'b0;
  logic [8:0]  slot_idx = '0;
  logic        data_ack = 1'b0;
  logic        line_end = 1'b0;
  logic [8:0]  new_line = '0;
  logic [8:0]  vwin_start = 9'd10;
  logic [8:0]  vwin_stop = 9'd20;
  logic        dma_bpl_en = 1'b0;
  logic        hires = 1'b0;
  logic [2:0]  plane_cnt = 3'd6;
  logic        fetch_req, did_fetch, eol_modulo;
  logic [2:0]  fetch_plane;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  bit m_h, m_last, m_v, m_did;
  int cur_start, cur_stop;

  always #HALF clk = ~clk;

  bpl_slot_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .slot_valid(slot_valid), .slot_idx(slot_idx),
    .data_ack(data_ack), .line_end(line_end), .new_line(new_line),
    .vwin_start(vwin_start), .vwin_stop(vwin_stop), .dma_bpl_en(dma_bpl_en),
    .hires(hires), .plane_cnt(plane_cnt), .fetch_req(fetch_req),
    .fetch_plane(fetch_plane), .did_fetch(did_fetch), .eol_modulo(eol_modulo)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Plane order from R7 / R8; -1 means no fetch slot.
  function automatic int ref_plane(input bit hi, input int s);
    if (hi) begin
      case (s % 4)
        0: return 3;
        1: return 1;
        2: return 2;
        default: return 0;
      endcase
    end
    case (s % 8)
      1: return 3;
      2: return 5;
      3: return 1;
      5: return 2;
      6: return 4;
      7: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic wr(input logic [8:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 9'h092) cur_start = d;
    if (a == 9'h094) cur_stop = d;
  endtask

  task automatic end_line(input string tag, input int lnum);
    bit exp_eol;
    exp_eol = m_did;
    line_end = 1'b1; new_line = 9'(lnum);
    @(negedge clk);
    line_end = 1'b0;
    check(tag, int'(eol_modulo), int'(exp_eol), "eol_modulo");
    check(tag, int'(did_fetch), 0, "did_fetch after line_end");
    if (lnum == int'(vwin_stop)) m_v = 0;
    else if (lnum == int'(vwin_start)) m_v = 1;
    m_h = 0; m_last = 0; m_did = 0;
    @(negedge clk);
    check(tag, int'(eol_modulo), 0, "eol_modulo single pulse");
  endtask

  // Presents slots lo..hi; data_ack on slot ack_at.
  task automatic sweep(input string tag, input int lo, input int hi, input int ack_at);
    for (int s = lo; s <= hi; s++) begin
      bit h, g;
      int p;
      slot_valid = 1'b1; slot_idx = 9'(s); data_ack = (s == ack_at);
      p = ref_plane(hires, s);
      h = m_h || (s == cur_start);
      g = dma_bpl_en && m_v && h && (p >= 0) && (p < int'(plane_cnt));
      m_last = m_last || (s == cur_stop);
      m_h = h && !((s == ack_at) && m_last);
      if (g) m_did = 1;
      @(negedge clk);
      check(tag, int'(fetch_req), int'(g), $sformatf("fetch_req slot %0h", s));
      if (g) check(tag, int'(fetch_plane), p, $sformatf("fetch_plane slot %0h", s));
      check("R11", int'(did_fetch), int'(m_did), $sformatf("did_fetch slot %0h", s));
    end
    slot_valid = 1'b0; data_ack = 1'b0;
    @(negedge clk);
    check("R10", int'(fetch_req), 0, "no request on idle cycle");
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", int'(fetch_req), 0, "fetch_req in reset");
    check("R1", int'(did_fetch), 0, "did_fetch in reset");
    check("R1", int'(eol_modulo), 0, "eol_modulo in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(fetch_req), 0, "fetch_req after reset");
    check("R1", int'(fetch_plane), 0, "fetch_plane after reset");
  endtask

  task automatic t_vertical_open();
    dma_bpl_en = 1'b1;
    wr(9'h092, 16'h0004); wr(9'h094, 16'h0040);
    sweep("R5", 4, 12, -1);          // vertical flag still clear
    end_line("R5", 10);              // opens vertically, no fetch seen
  endtask

  task automatic t_regs_full_word();
    wr(9'h092, 16'h0103); wr(9'h094, 16'h0110);
    wr(9'h090, 16'h0100);            // unrelated offset: R2 ignored
    sweep("R2", 9'h100, 9'h118, 9'h112);
    end_line("R11", 11);
  endtask

  task automatic t_start_slot_and_stop();
    wr(9'h092, 16'h0021); wr(9'h094, 16'h0028);
    sweep("R3", 9'h20, 9'h34, 9'h2C); // window runs past stop to ack (R4)
    end_line("R4", 12);
    sweep("R4", 9'h22, 9'h2A, -1);    // no new start match: closed (R11)
    end_line("R11", 13);
  endtask

  task automatic t_hires();
    hires = 1'b1;
    wr(9'h092, 16'h0010); wr(9'h094, 16'h0017);
    sweep("R8", 9'h0C, 9'h1C, 9'h18);
    end_line("R8", 14);
    hires = 1'b0;
  endtask

  task automatic t_plane_count();
    plane_cnt = 3'd3;
    wr(9'h092, 16'h0040); wr(9'h094, 16'h0050);
    sweep("R9", 9'h40, 9'h52, 9'h51);
    end_line("R9", 15);
    plane_cnt = 3'd0;
    sweep("R9", 9'h40, 9'h48, -1);
    end_line("R9", 16);
    plane_cnt = 3'd6;
  endtask

  task automatic t_lores_order();
    wr(9'h092, 16'h0080); wr(9'h094, 16'h0090);
    sweep("R7", 9'h80, 9'h92, 9'h91);
    end_line("R7", 17);
  endtask

  task automatic t_dma_off();
    dma_bpl_en = 1'b0;
    sweep("R6", 9'h80, 9'h8C, -1);
    end_line("R6", 18);
    dma_bpl_en = 1'b1;
  endtask

  task automatic t_invalid_slot();
    slot_valid = 1'b0; slot_idx = 9'h080;   // start index without a slot
    @(negedge clk);
    check("R10", int'(fetch_req), 0, "no request without slot_valid");
    sweep("R10", 9'h81, 9'h88, -1);          // window never opened
    end_line("R10", 19);
  endtask

  task automatic t_vertical_close();
    end_line("R5", 20);                      // stop line clears the flag
    sweep("R5", 9'h80, 9'h88, -1);
    end_line("R5", 21);
  endtask

  initial begin
    m_h = 0; m_last = 0; m_v = 0; m_did = 0;
    cur_start = 0; cur_stop = 0;
    t_reset();
    t_vertical_open();
    t_regs_full_word();
    t_start_slot_and_stop();
    t_hires();
    t_plane_count();
    t_lores_order();
    t_dma_off();
    t_invalid_slot();
    t_vertical_close();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule